// File: doc/BRIEF.md
# Condition Code Pass Gate

This block decides whether an instruction is allowed to take effect. It reads a four-bit condition selector from the instruction word and the four arithmetic flags (negative, zero, carry, overflow) from the packed status word, and drives a single `take` signal. The flags occupy the top four bits of the status word. All other status bits are ignored.

Two instruction formats are supported. In wide mode the selector is the top nibble of the 32-bit instruction and every instruction is evaluated. In narrow (compressed) mode only conditional branches carry a selector, in bits 11:8. All other narrow instructions pass unconditionally. The selector value 15 passes like 14, and a separate `cc_reserved` output marks it so that the decoder can treat it as a special encoding.

The result path is either purely combinational or registered once, chosen by the `OUT_REG` parameter. Both variants share the same evaluation logic. Control pins are plain levels: there is no handshake, because the block has no storage that back-pressure could affect.

Top module: `cond_gate`

## Requirements
- R1: Flags are read from status bits N=31, Z=30, C=29, V=28; status bits 27:0 have no effect on either output.
- R2: Selector 0 passes when Z=1; selector 1 passes when Z=0.
- R3: Selector 2 passes when C=1; selector 3 passes when C=0.
- R4: Selectors 4 and 5 pass on N=1 and N=0; selectors 6 and 7 pass on V=1 and V=0.
- R5: Selector 8 passes when C=1 and Z=0; selector 9 passes when C=0 or Z=1.
- R6: Selector 10 passes when N equals V; selector 11 passes when N differs from V.
- R7: Selector 12 passes when Z=0 and N equals V; selector 13 passes when Z=1 or N differs from V.
- R8: Selector 14 always passes. Selector 15 also always passes and raises `cc_reserved`. `cc_reserved` is 0 for every other evaluated selector.
- R9: With `narrow_mode`=0 the selector is instruction bits 31:28, and instruction bits 27:0 have no effect.
- R10: With `narrow_mode`=1 and `narrow_is_bcc`=1 the selector is instruction bits 11:8, evaluated with the same table.
- R11: With `narrow_mode`=1 and `narrow_is_bcc`=0, `take`=1 and `cc_reserved`=0 whatever the selector bits and flags are.
- R12: With `OUT_REG`=1 the outputs follow the inputs one clock later and are 0 while `rst_n` is low. With `OUT_REG`=0 they follow the inputs in the same cycle.
- R13: In wide mode `narrow_is_bcc` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| stat_word | input | 32 | Packed status word; flags in bits 31:28 |
| insn | input | 32 | Instruction word carrying the selector |
| narrow_mode | input | 1 | 1 = compressed 16-bit format, 0 = wide format |
| narrow_is_bcc | input | 1 | In narrow mode, 1 marks a conditional branch |
| take | output | 1 | Instruction executes |
| cc_reserved | output | 1 | Selector 15 was evaluated |

## Verification
The bench builds two copies side by side: one with `OUT_REG`=1 and one with `OUT_REG`=0. Both are driven from the same stimulus and checked against one reference model. Together they reach the reset behaviour and the one-cycle delay of the registered path, and they show that the combinational path has no delay. The default widths and field positions are used in both copies, so all 256 selector and flag pairs are swept in each format, with random filler in the bits that must be ignored.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flag_set_t;

  typedef enum logic [2:0] {
    GRP_ZERO  = 3'd0,
    GRP_CARRY = 3'd1,
    GRP_NEG   = 3'd2,
    GRP_OVF   = 3'd3,
    GRP_UNS   = 3'd4,
    GRP_SGE   = 3'd5,
    GRP_SGT   = 3'd6,
    GRP_ANY   = 3'd7
  } cc_group_e;

  localparam int unsigned SEL_W = 4;
endpackage

// File: rtl/cc_field_pick.sv
module cc_field_pick
  import cond_gate_pkg::*;
#(
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned NARROW_LO = 8
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              narrow_mode,
  input  logic              narrow_is_bcc,
  output logic [SEL_W-1:0]  sel,
  output logic              eval_en
);
  localparam int unsigned WIDE_LO = INSN_W - SEL_W;

  always_comb begin
    if (narrow_mode) begin
      sel     = insn[NARROW_LO +: SEL_W];
      eval_en = narrow_is_bcc;
    end else begin
      sel     = insn[WIDE_LO +: SEL_W];
      eval_en = 1'b1;
    end
  end
endmodule

// File: rtl/cc_flag_eval.sv
module cc_flag_eval
  import cond_gate_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] stat_word,
  input  logic [SEL_W-1:0]  sel,
  input  logic              eval_en,
  output logic              pass_c,
  output logic              rsvd_c
);
  localparam int unsigned FLAG_LO = WORD_W - SEL_W;

  flag_set_t fl;
  cc_group_e grp;
  logic      base;
  logic      sgn_eq;

  assign fl     = flag_set_t'(stat_word[FLAG_LO +: SEL_W]);
  assign grp    = cc_group_e'(sel[SEL_W-1:1]);
  assign sgn_eq = (fl.neg == fl.ovf);

  always_comb begin
    unique case (grp)
      GRP_ZERO:  base = fl.zero;
      GRP_CARRY: base = fl.carry;
      GRP_NEG:   base = fl.neg;
      GRP_OVF:   base = fl.ovf;
      GRP_UNS:   base = fl.carry & ~fl.zero;
      GRP_SGE:   base = sgn_eq;
      GRP_SGT:   base = ~fl.zero & sgn_eq;
      default:   base = 1'b1;
    endcase
  end

  always_comb begin
    if (!eval_en) begin
      pass_c = 1'b1;
      rsvd_c = 1'b0;
    end else if (grp == GRP_ANY) begin
      pass_c = 1'b1;
      rsvd_c = sel[0];
    end else begin
      pass_c = base ^ sel[0];
      rsvd_c = 1'b0;
    end
  end
endmodule

// File: rtl/cc_out_stage.sv
module cc_out_stage #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_c,
  input  logic rsvd_c,
  output logic take,
  output logic cc_reserved
);
  generate
    if (OUT_REG) begin : g_reg
      logic take_q, rsvd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          take_q <= 1'b0;
          rsvd_q <= 1'b0;
        end else begin
          take_q <= pass_c;
          rsvd_q <= rsvd_c;
        end
      end
      assign take        = take_q;
      assign cc_reserved = rsvd_q;
    end else begin : g_comb
      assign take        = pass_c;
      assign cc_reserved = rsvd_c;
    end
  endgenerate
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_gate_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned NARROW_LO = 8,
  parameter bit          OUT_REG   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] stat_word,
  input  logic [INSN_W-1:0] insn,
  input  logic              narrow_mode,
  input  logic              narrow_is_bcc,
  output logic              take,
  output logic              cc_reserved
);
  logic [SEL_W-1:0] sel;
  logic             eval_en;
  logic             pass_c;
  logic             rsvd_c;

  cc_field_pick #(
    .INSN_W   (INSN_W),
    .NARROW_LO(NARROW_LO)
  ) u_pick (
    .insn         (insn),
    .narrow_mode  (narrow_mode),
    .narrow_is_bcc(narrow_is_bcc),
    .sel          (sel),
    .eval_en      (eval_en)
  );

  cc_flag_eval #(
    .WORD_W(WORD_W)
  ) u_eval (
    .stat_word(stat_word),
    .sel      (sel),
    .eval_en  (eval_en),
    .pass_c   (pass_c),
    .rsvd_c   (rsvd_c)
  );

  cc_out_stage #(
    .OUT_REG(OUT_REG)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_c     (pass_c),
    .rsvd_c     (rsvd_c),
    .take       (take),
    .cc_reserved(cc_reserved)
  );
endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned NARROW_LO = 8,
  parameter bit          OUT_REG   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] stat_word,
  input logic [INSN_W-1:0] insn,
  input logic              narrow_mode,
  input logic              narrow_is_bcc,
  input logic              take,
  input logic              cc_reserved
);
  logic [3:0] cur_sel;
  logic       cur_ev;
  logic [3:0] cur_fl;
  logic [3:0] o_sel;
  logic       o_ev;
  logic [3:0] o_fl;
  logic       o_ok;

  assign cur_sel = narrow_mode ? insn[NARROW_LO +: 4] : insn[INSN_W-1 -: 4];
  assign cur_ev  = !narrow_mode || narrow_is_bcc;
  assign cur_fl  = stat_word[WORD_W-1 -: 4];

  generate
    if (OUT_REG) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          o_sel <= '0;
          o_ev  <= 1'b0;
          o_fl  <= '0;
          o_ok  <= 1'b0;
        end else begin
          o_sel <= cur_sel;
          o_ev  <= cur_ev;
          o_fl  <= cur_fl;
          o_ok  <= 1'b1;
        end
      end
    end else begin : g_now
      assign o_sel = cur_sel;
      assign o_ev  = cur_ev;
      assign o_fl  = cur_fl;
      assign o_ok  = 1'b1;
    end
  endgenerate

  // o_fl = {N, Z, C, V}
  a_r2_zero_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_ev && o_sel[3:1] == 3'd0) |-> (take == (o_fl[2] ^ o_sel[0])));

  a_r3_carry_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_ev && o_sel[3:1] == 3'd1) |-> (take == (o_fl[1] ^ o_sel[0])));

  a_r5_unsigned_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_ev && o_sel == 4'd8) |-> (take == (o_fl[1] && !o_fl[2])));

  a_r6_signed_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_ev && o_sel == 4'd11) |-> (take == (o_fl[3] != o_fl[0])));

  a_r8_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    o_ok |-> (cc_reserved == (o_ev && o_sel == 4'd15)));

  a_r8_always_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && o_sel[3:1] == 3'd7) |-> take);

  a_r11_narrow_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (o_ok && !o_ev) |-> (take && !cc_reserved));
endmodule

bind cond_gate cond_gate_chk #(
  .WORD_W   (WORD_W),
  .INSN_W   (INSN_W),
  .NARROW_LO(NARROW_LO),
  .OUT_REG  (OUT_REG)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stat_word    (stat_word),
  .insn         (insn),
  .narrow_mode  (narrow_mode),
  .narrow_is_bcc(narrow_is_bcc),
  .take         (take),
  .cc_reserved  (cc_reserved)
);

// File: tb/cond_gate_bench.sv
`timescale 1ns/1ps
module cond_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] stat_word = '0;
  logic [31:0] insn = 32'hE000_0000;
  logic        narrow_mode = 1'b0;
  logic        narrow_is_bcc = 1'b0;
  logic        take_r, rsvd_r, take_c, rsvd_c;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cond_gate #(.OUT_REG(1'b1)) u_cond_gate (
    .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .insn(insn),
    .narrow_mode(narrow_mode), .narrow_is_bcc(narrow_is_bcc),
    .take(take_r), .cc_reserved(rsvd_r)
  );

  cond_gate #(.OUT_REG(1'b0)) u_cond_gate_c (
    .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .insn(insn),
    .narrow_mode(narrow_mode), .narrow_is_bcc(narrow_is_bcc),
    .take(take_c), .cc_reserved(rsvd_c)
  );

  // Reference: explicit truth table per selector value.
  function automatic bit ref_take(int code, bit n, bit z, bit c, bit v);
    case (code)
      0:  return z;
      1:  return !z;
      2:  return c;
      3:  return !c;
      4:  return n;
      5:  return !n;
      6:  return v;
      7:  return !v;
      8:  return c && !z;
      9:  return !c || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive one vector, wait one edge, then compare both variants.
  task automatic apply(string req, logic [31:0] sw, logic [31:0] iw,
                       bit nm, bit bcc, bit et, bit er);
    @(negedge clk);
    stat_word = sw; insn = iw; narrow_mode = nm; narrow_is_bcc = bcc;
    @(posedge clk);
    #1;
    check(req, "take reg",     take_r, et);
    check(req, "reserved reg", rsvd_r, er);
    check(req, "take comb",    take_c, et);
    check(req, "reserved comb", rsvd_c, er);
  endtask

  function automatic string req_of(int code);
    if (code < 2) return "R2";
    if (code < 4) return "R3";
    if (code < 8) return "R4";
    if (code < 10) return "R5";
    if (code < 12) return "R6";
    if (code < 14) return "R7";
    return "R8";
  endfunction

  initial begin
    // R12: registered copy held low in reset even with an always-pass selector
    repeat (3) @(posedge clk);
    #1;
    check("R12", "reset take",     take_r, 1'b0);
    check("R12", "reset reserved", rsvd_r, 1'b0);
    check("R12", "comb take in reset", take_c, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 with R1..R8: wide mode sweep, random filler in ignored bits
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] sw, iw;
        bit exp;
        sw = {f[3:0], 28'($urandom)};
        iw = {code[3:0], 28'($urandom)};
        exp = ref_take(code, f[3], f[2], f[1], f[0]);
        apply(req_of(code), sw, iw, 1'b0, 1'($urandom), exp, code == 15);
      end
    end

    // R10: narrow branch sweep on bits 11:8, other bits random
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] sw, iw;
        bit exp;
        sw = {f[3:0], 28'($urandom)};
        iw = $urandom;
        iw[11:8] = code[3:0];
        exp = ref_take(code, f[3], f[2], f[1], f[0]);
        apply("R10", sw, iw, 1'b1, 1'b1, exp, code == 15);
      end
    end

    // R11: narrow non-branch always passes, never reserved
    for (int k = 0; k < 32; k++) begin
      logic [31:0] iw;
      iw = $urandom;
      if (k < 16) iw[11:8] = 4'(k);
      apply("R11", {4'(k), 28'($urandom)}, iw, 1'b1, 1'b0, 1'b1, 1'b0);
    end

    // R13: wide mode, same vector with bcc toggled
    apply("R13", 32'h4000_0000, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R13", 32'h4000_0000, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R13", 32'hF000_0000, 32'hF000_0000, 1'b0, 1'b1, 1'b1, 1'b1);

    // R1: low status bits all set with flags clear; selector 0 (Z) must fail
    apply("R1", 32'h0FFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R1", 32'h4000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0);

    // R12: registered copy lags by one cycle; check just after the change
    @(negedge clk);
    stat_word = 32'h0000_0000; insn = 32'h0000_0000; narrow_mode = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    stat_word = 32'h4000_0000;
    #1;
    check("R12", "comb same cycle", take_c, 1'b1);
    check("R12", "reg still old",   take_r, 1'b0);
    @(posedge clk); #1;
    check("R12", "reg one later",   take_r, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule